// File: doc/BRIEF.md
# Busy Resource Countdown Tracker

This block keeps a table of occupied execution resources. Each resource reference is a pair of masks: a primary mask and a sub-unit mask. When an operation issues, the block receives one resource use per clock. A use gives the reference, a reserved-group flag and an occupancy length in cycles. The length is added to a countdown counter for that reference. If no entry holds the reference yet, a free entry is allocated for it.

A per-cycle tick decrements every live counter. When a counter reaches zero, the entry is freed and reported. The report is registered and lasts one cycle:

- a per-entry freed bit-vector;
- the freed entries' keys;
- resource-level release strobes;
- sub-unit release strobes for the unit-availability logic.

A use of length zero never takes an entry. Its primary mask is released at once.

Top module: `busy_countdown`

## Requirements
- R1: After reset no entry is live, `full_o` is low, and `free_vec_o`, `res_rel_o` and `sub_rel_o` are all zero.
- R2: A use of length L>0 to a reference not held by any entry is freed exactly on the L-th tick edge after the issue edge. `free_vec_o` for that entry is high for the cycle after that edge, and never earlier.
- R3: A use with length zero allocates no entry. Its `issue_pri_i` mask appears in `res_rel_o` in the cycle after the issue edge.
- R4: A non-reserved use is keyed by (`issue_pri_i`, `issue_sub_i`). A reserved use (`issue_reserved_i`=1) is keyed by (`issue_pri_i`, `issue_pri_i`). Entry i's key is reported on `free_pri_o[i*W +: W]` and `free_sub_o[i*W +: W]` while `free_vec_o[i]` is high.
- R5: A use whose key matches a live entry adds its length to that entry's remaining count; no new entry is taken.
- R6: When a tick and a matching use meet in one cycle, the count is decremented first and the length is then added. The entry is not freed in that cycle, even if the decremented count is zero.
- R7: `res_rel_o` is the OR of the primary masks of the entries freed on the edge, plus any zero-length primary. `sub_rel_o[i]` is set exactly when entry i is freed and its primary mask has one bit set.
- R8: A new key takes the lowest-index free entry. `full_o` is high when all entries are live. A new-key use of nonzero length while full is dropped.
- R9: An accumulated count saturates at 2^CW-1.
- R10: Without a tick, no count changes and nothing is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | A resource use is presented this cycle |
| issue_reserved_i | input | 1 | The use is a reserved group; key is (pri, pri) |
| issue_pri_i | input | W | Primary mask of the use |
| issue_sub_i | input | W | Sub-unit mask of the use |
| issue_len_i | input | CW | Occupancy length in cycles |
| tick_i | input | 1 | Cycle event: decrement all live counters |
| full_o | output | 1 | No free entry remains |
| free_vec_o | output | N | Entries freed on the last edge |
| free_pri_o | output | N*W | Primary mask of each freed entry |
| free_sub_o | output | N*W | Sub-unit mask of each freed entry |
| res_rel_o | output | W | Resource-level release strobes |
| sub_rel_o | output | N | Sub-unit release strobe per freed entry |

## Verification
The bench targets the following corner cases:

- **Length sweep.** Every length is swept from 1 to the counter maximum. A design off by one cycle in its countdown would free one tick early or late.
- **Accumulation and saturation.** These show whether a repeated key takes a second entry or wraps its count.
- **Tick and issue in the same cycle.** This case separates a design that frees and then drops the added length from one that decrements before adding.
- **Primary-mask width and full table.** Multi-bit primaries catch a sub-unit release that ignores the one-hot rule. Filling the table catches allocation that overwrites a live entry.
- **Long mixed run.** A long pseudo-random mixed run is compared every cycle against an arithmetic table model.

// File: rtl/busy_countdown_pkg.sv
package busy_countdown_pkg;
  localparam int unsigned DEF_ENTRIES = 4;
  localparam int unsigned DEF_MASK_W  = 4;
  localparam int unsigned DEF_CNT_W   = 4;

  typedef enum logic {ENT_IDLE = 1'b0, ENT_BUSY = 1'b1} ent_state_e;
endpackage

// File: rtl/bc_entry.sv
module bc_entry
  import busy_countdown_pkg::*;
#(
  parameter int unsigned W  = DEF_MASK_W,
  parameter int unsigned CW = DEF_CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          add_i,
  input  logic [CW-1:0] add_len_i,
  input  logic [W-1:0]  key_pri_i,
  input  logic [W-1:0]  key_sub_i,
  output logic          valid_o,
  output logic [W-1:0]  pri_o,
  output logic [W-1:0]  sub_o,
  output logic          free_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  ent_state_e    state_q;
  logic [CW-1:0] cnt_q, cnt_dec, cnt_sat;
  logic [CW:0]   cnt_sum;
  logic [W-1:0]  pri_q, sub_q;
  logic          live;

  assign live    = (state_q == ENT_BUSY);
  // decrement before add
  assign cnt_dec = (tick_i && live && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
  assign cnt_sum = {1'b0, cnt_dec} + {1'b0, add_len_i};
  assign cnt_sat = cnt_sum[CW] ? CNT_MAX : cnt_sum[CW-1:0];
  assign free_o  = live && tick_i && (cnt_dec == '0) && !add_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENT_IDLE;
      cnt_q   <= '0;
      pri_q   <= '0;
      sub_q   <= '0;
    end else if (add_i) begin
      state_q <= ENT_BUSY;
      cnt_q   <= cnt_sat;
      pri_q   <= key_pri_i;
      sub_q   <= key_sub_i;
    end else if (free_o) begin
      state_q <= ENT_IDLE;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_dec;
    end
  end

  assign valid_o = live;
  assign pri_o   = pri_q;
  assign sub_o   = sub_q;
endmodule

// File: rtl/bc_match.sv
module bc_match #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 4
) (
  input  logic [N-1:0]   valid_i,
  input  logic [N*W-1:0] pri_i,
  input  logic [N*W-1:0] sub_i,
  input  logic [W-1:0]   key_pri_i,
  input  logic [W-1:0]   key_sub_i,
  output logic [N-1:0]   hit_o,
  output logic           any_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_o[i] = valid_i[i] && (pri_i[i*W +: W] == key_pri_i)
                                 && (sub_i[i*W +: W] == key_sub_i);
  end
  assign any_o = |hit_o;
endmodule

// File: rtl/bc_alloc.sv
module bc_alloc #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] grant_o,
  output logic         any_free_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  // lowest-index idle entry wins
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant_o[i]  = !valid_i[i] && !seen[i];
    assign seen[i+1]   = seen[i] || !valid_i[i];
  end
  assign any_free_o = seen[N];
endmodule

// File: rtl/busy_countdown.sv
module busy_countdown
  import busy_countdown_pkg::*;
#(
  parameter int unsigned N  = DEF_ENTRIES,
  parameter int unsigned W  = DEF_MASK_W,
  parameter int unsigned CW = DEF_CNT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           issue_valid_i,
  input  logic           issue_reserved_i,
  input  logic [W-1:0]   issue_pri_i,
  input  logic [W-1:0]   issue_sub_i,
  input  logic [CW-1:0]  issue_len_i,
  input  logic           tick_i,
  output logic           full_o,
  output logic [N-1:0]   free_vec_o,
  output logic [N*W-1:0] free_pri_o,
  output logic [N*W-1:0] free_sub_o,
  output logic [W-1:0]   res_rel_o,
  output logic [N-1:0]   sub_rel_o
);
  logic [W-1:0]   key_sub;
  logic           use_busy, use_zero;
  logic [N-1:0]   ent_valid, ent_free, hit_vec, grant_vec, add_vec;
  logic [N*W-1:0] ent_pri, ent_sub;
  logic           any_hit, any_free;
  logic [W-1:0]   rel_d;
  logic [N-1:0]   sub_d;

  assign key_sub  = issue_reserved_i ? issue_pri_i : issue_sub_i;
  assign use_busy = issue_valid_i && (issue_len_i != '0);
  assign use_zero = issue_valid_i && (issue_len_i == '0);

  bc_match #(.N(N), .W(W)) u_match (
    .valid_i   (ent_valid),
    .pri_i     (ent_pri),
    .sub_i     (ent_sub),
    .key_pri_i (issue_pri_i),
    .key_sub_i (key_sub),
    .hit_o     (hit_vec),
    .any_o     (any_hit)
  );

  bc_alloc #(.N(N)) u_alloc (
    .valid_i    (ent_valid),
    .grant_o    (grant_vec),
    .any_free_o (any_free)
  );

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign add_vec[i] = use_busy && (any_hit ? hit_vec[i] : grant_vec[i]);

    bc_entry #(.W(W), .CW(CW)) u_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .add_i     (add_vec[i]),
      .add_len_i (issue_len_i),
      .key_pri_i (issue_pri_i),
      .key_sub_i (key_sub),
      .valid_o   (ent_valid[i]),
      .pri_o     (ent_pri[i*W +: W]),
      .sub_o     (ent_sub[i*W +: W]),
      .free_o    (ent_free[i])
    );

    assign sub_d[i] = ent_free[i] && ($countones(ent_pri[i*W +: W]) == 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        free_pri_o[i*W +: W] <= '0;
        free_sub_o[i*W +: W] <= '0;
      end else if (ent_free[i]) begin
        free_pri_o[i*W +: W] <= ent_pri[i*W +: W];
        free_sub_o[i*W +: W] <= ent_sub[i*W +: W];
      end
    end
  end

  always_comb begin
    rel_d = use_zero ? issue_pri_i : '0;
    for (int i = 0; i < N; i++) begin
      if (ent_free[i]) rel_d = rel_d | ent_pri[i*W +: W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_vec_o <= '0;
      res_rel_o  <= '0;
      sub_rel_o  <= '0;
    end else begin
      free_vec_o <= ent_free;
      res_rel_o  <= rel_d;
      sub_rel_o  <= sub_d;
    end
  end

  assign full_o = !any_free;
endmodule

// File: rtl/busy_countdown_chk.sv
module busy_countdown_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 4,
  parameter int unsigned CW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           issue_valid_i,
  input logic           issue_reserved_i,
  input logic [W-1:0]   issue_pri_i,
  input logic [W-1:0]   issue_sub_i,
  input logic [CW-1:0]  issue_len_i,
  input logic           tick_i,
  input logic           full_o,
  input logic [N-1:0]   free_vec_o,
  input logic [N*W-1:0] free_pri_o,
  input logic [N*W-1:0] free_sub_o,
  input logic [W-1:0]   res_rel_o,
  input logic [N-1:0]   sub_rel_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (free_vec_o == '0 && res_rel_o == '0 && sub_rel_o == '0);
    end
  end

  p_sub_in_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_rel_o & ~free_vec_o) == '0);

  p_free_needs_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_vec_o != '0) |-> $past(tick_i));

  p_zero_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_len_i == '0) |=>
      ((res_rel_o & $past(issue_pri_i)) == $past(issue_pri_i)));

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_sub_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sub_rel_o[i] |-> $onehot(free_pri_o[i*W +: W]));
    p_sub_taken_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (free_vec_o[i] && $onehot(free_pri_o[i*W +: W])) |-> sub_rel_o[i]);
    p_res_cover_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      free_vec_o[i] |-> ((res_rel_o & free_pri_o[i*W +: W]) == free_pri_o[i*W +: W]));
  end
endmodule

bind busy_countdown busy_countdown_chk #(.N(N), .W(W), .CW(CW)) u_chk (.*);

// File: tb/busy_countdown_bench.sv
module busy_countdown_bench;
  localparam int N  = 4;
  localparam int W  = 4;
  localparam int CW = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           issue_valid_i = 1'b0;
  logic           issue_reserved_i = 1'b0;
  logic [W-1:0]   issue_pri_i = '0;
  logic [W-1:0]   issue_sub_i = '0;
  logic [CW-1:0]  issue_len_i = '0;
  logic           tick_i = 1'b0;
  logic           full_o;
  logic [N-1:0]   free_vec_o;
  logic [N*W-1:0] free_pri_o, free_sub_o;
  logic [W-1:0]   res_rel_o;
  logic [N-1:0]   sub_rel_o;

  always #4 clk_i = ~clk_i;

  busy_countdown #(.N(N), .W(W), .CW(CW)) u_busy_countdown (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  bit         m_v   [N];
  int         m_cnt [N];
  logic [W-1:0] m_p [N];
  logic [W-1:0] m_s [N];

  logic [N-1:0] e_free;
  logic [W-1:0] e_rel;
  logic [N-1:0] e_sub;
  logic [W-1:0] e_p [N];
  logic [W-1:0] e_s [N];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive, predict, clock, compare
  task automatic step(input bit v, input bit rsv, input logic [W-1:0] p,
                      input logic [W-1:0] s, input int len, input bit tk);
    logic [W-1:0] ks;
    int hit, alloc;
    bit allfull;
    @(negedge clk_i);
    issue_valid_i = v; issue_reserved_i = rsv; issue_pri_i = p;
    issue_sub_i = s; issue_len_i = CW'(len); tick_i = tk;
    ks = rsv ? p : s;
    hit = -1; alloc = -1; allfull = 1;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_p[i] == p && m_s[i] == ks && hit < 0) hit = i;
      if (!m_v[i] && alloc < 0) alloc = i;
      if (!m_v[i]) allfull = 0;
    end
    #1;
    chk("R8 full", int'(full_o), int'(allfull));
    e_free = '0; e_sub = '0;
    e_rel = (v && len == 0) ? p : '0;
    for (int i = 0; i < N; i++) begin
      int cd;
      bit add;
      cd = (tk && m_v[i]) ? m_cnt[i] - 1 : m_cnt[i];
      add = v && len != 0 && ((hit >= 0) ? (hit == i) : (alloc == i));
      if (add) begin
        m_v[i] = 1; m_cnt[i] = (cd + len > MAXC) ? MAXC : cd + len;
        m_p[i] = p; m_s[i] = ks;
      end else if (m_v[i] && tk && cd == 0) begin
        e_free[i] = 1; e_p[i] = m_p[i]; e_s[i] = m_s[i];
        e_rel = e_rel | m_p[i];
        e_sub[i] = ($countones(m_p[i]) == 1);
        m_v[i] = 0; m_cnt[i] = 0;
      end else begin
        m_cnt[i] = cd;
      end
    end
    @(posedge clk_i);
    #2;
    chk("R2 free_vec", int'(free_vec_o), int'(e_free));
    chk("R7 res_rel", int'(res_rel_o), int'(e_rel));
    chk("R7 sub_rel", int'(sub_rel_o), int'(e_sub));
    for (int i = 0; i < N; i++) if (e_free[i]) begin
      chk("R4 key pri", int'(free_pri_o[i*W +: W]), int'(e_p[i]));
      chk("R4 key sub", int'(free_sub_o[i*W +: W]), int'(e_s[i]));
    end
  endtask

  task automatic idle(input bit tk); step(0, 0, '0, '0, 0, tk); endtask

  // tick until entry idx frees; return tick count
  task automatic ticks_to_free(input int idx, output int n);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      step(0, 0, '0, '0, 0, 1);
      n++;
      if (free_vec_o[idx]) return;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 20; k++) idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_cnt[i] = 0; m_p[i] = '0; m_s[i] = '0; end
    repeat (3) @(posedge clk_i);
    #2;
    chk("R1 free_vec", int'(free_vec_o), 0);
    chk("R1 res_rel", int'(res_rel_o), 0);
    chk("R1 sub_rel", int'(sub_rel_o), 0);
    chk("R1 full", int'(full_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2: sweep all lengths
    for (int L = 1; L <= MAXC; L++) begin
      step(1, 0, 4'b0010, 4'b0100, L, 0);
      ticks_to_free(0, n);
      chk("R2 tick count", n, L);
    end

    // R10: no tick, nothing moves
    step(1, 0, 4'b0001, 4'b0001, 2, 0);
    for (int k = 0; k < 5; k++) idle(0);
    chk("R10 held", int'(free_vec_o), 0);
    ticks_to_free(0, n);
    chk("R10 count kept", n, 2);

    // R3: zero length
    step(1, 0, 4'b1000, 4'b0010, 0, 0);
    chk("R3 res_rel", int'(res_rel_o), 4'b1000);
    chk("R3 no entry", int'(full_o), 0);

    // R5: accumulation
    step(1, 0, 4'b0100, 4'b0001, 3, 0);
    step(1, 0, 4'b0100, 4'b0001, 4, 0);
    ticks_to_free(0, n);
    chk("R5 accumulated", n, 7);

    // R6: tick and add in same cycle at count 1
    step(1, 0, 4'b0010, 4'b0010, 1, 0);
    step(1, 0, 4'b0010, 4'b0010, 2, 1);
    chk("R6 not freed", int'(free_vec_o), 0);
    ticks_to_free(0, n);
    chk("R6 remaining", n, 2);

    // R9: saturation
    step(1, 0, 4'b0001, 4'b1000, MAXC, 0);
    step(1, 0, 4'b0001, 4'b1000, 5, 0);
    ticks_to_free(0, n);
    chk("R9 saturated", n, MAXC);

    // R4 reserved key, R7 multi-bit primary
    step(1, 1, 4'b0110, 4'b0001, 1, 0);
    idle(1);
    chk("R4 reserved sub", int'(free_sub_o[3:0]), 4'b0110);
    chk("R7 no sub rel", int'(sub_rel_o), 0);

    // R8: fill table, lowest index, drop when full
    step(1, 0, 4'b0001, 4'b0001, 5, 0);
    step(1, 0, 4'b0010, 4'b0001, 6, 0);
    step(1, 0, 4'b0100, 4'b0001, 7, 0);
    step(1, 0, 4'b1000, 4'b0001, 8, 0);
    step(1, 0, 4'b1000, 4'b0010, 2, 0);
    idle(1); idle(1);
    chk("R8 dropped", int'(free_vec_o), 0);
    ticks_to_free(3, n);
    chk("R8 entry3 len", n, 6);
    drain();

    // long mixed run against model
    lfsr = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      logic [W-1:0] p, s;
      int len;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: p = 4'b0001; 2'd1: p = 4'b0010; 2'd2: p = 4'b0110; default: p = 4'b1000;
      endcase
      s = 4'b0001 << lfsr[3:2];
      len = (lfsr[6:4] == 0) ? 0 : int'(lfsr[11:8]) % 6;
      step(lfsr[12] & lfsr[7], lfsr[14] & lfsr[13], p, s, len, lfsr[15] | lfsr[2]);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule